// File: doc/BRIEF.md
# Memory Security Lockout Recovery Sequencer

This block owns the security state of an on-chip non-volatile memory and the one path that leads out of it. When reset is asserted it compares a set of stored key bytes against a secure signature and, if they match, raises a debug read block output. That output stops the debug port from reading internal memory, and it holds its value for the whole session that follows.

A part that was secured by mistake is recovered through a dedicated test instruction. A decoder outside this block reports that instruction with a level flag. Before the flag can do anything, a divider value for the erase timing must have been loaded. A request that arrives before the divider is present is held pending until the load comes in. The sequencer then drives a mass-erase request to the memory model and waits for its done pulse. On that pulse it issues a one-cycle protection-clear strobe and parks in a terminal state. The debug block drops only at the next reset, and only if the key bytes no longer match. An erased array reads all ones, so a completed erase leaves no match.

Top module: `sec_recovery_seq`

## Requirements
- R1: On a cycle with `rst` high, `dbg_rd_block` is loaded from `sec_key`. It becomes 1 when every key byte equals the secure byte (default 8'hA5) and 0 otherwise, and it is visible in the cycle after that clock edge.
- R2: Between resets `dbg_rd_block` holds its value, whatever happens on `sec_key`, `recov_instr`, `erase_done` or the divider inputs.
- R3: While the sequencer is idle and `recov_instr` is low, `erase_req` stays 0 and `busy` stays 0.
- R4: If `recov_instr` is seen while no divider has been loaded since reset, the request is held pending: `busy` is 1 and `erase_req` is 0. The cycle after the edge at which `div_load` is accepted, the pending request moves to erasing.
- R5: If `recov_instr` is seen with a divider already loaded, `erase_req` becomes 1 in the cycle after that edge. It stays 1 until the edge that samples `erase_done` high.
- R6: The edge that samples `erase_done` while erasing drops `erase_req` and raises `prot_clr` for exactly one cycle.
- R7: Once an erase has completed, the sequencer stays in its terminal state until reset: `busy` is 1, `erase_req` is 0, and further `recov_instr` or `erase_done` pulses have no effect.
- R8: `erase_clkdiv` shows the last value accepted through `div_load` (0 after reset). A load while erasing or after completion is ignored.
- R9: A reset during erasing returns the sequencer to idle, clears the divider-valid state and samples `sec_key` again. If the key still matches, `dbg_rd_block` stays 1.
- R10: `busy` is 1 in every state other than idle: pending, erasing and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the key bytes |
| sec_key | input | 8*KEY_BYTES | Stored security key bytes from the memory array |
| recov_instr | input | 1 | Recovery instruction decoded and active in the test controller |
| div_load | input | 1 | Load strobe for the erase-timing divider |
| div_value | input | DIV_W | Divider value (prescaler flag in the top bit, divisor below it) |
| erase_done | input | 1 | Mass-erase completion pulse from the memory model |
| erase_req | output | 1 | Mass-erase request, held for the whole erase |
| erase_clkdiv | output | DIV_W | Divider value applied to the erase timing |
| prot_clr | output | 1 | One-cycle strobe that clears the protection register |
| dbg_rd_block | output | 1 | Blocks debug reads of internal memory |
| busy | output | 1 | Sequencer is not idle |

## Verification
A corrupted latched security bit shows up on `dbg_rd_block` in the first cycle after reset. Any flip between resets is visible on the next cycle. A controller state that is wrong appears within one cycle on `busy` or `erase_req`. Examples are starting without a divider, leaving the terminal state, or missing the done pulse. A divider register that takes a load while erasing changes `erase_clkdiv` on the following cycle. The bench compares every output on every cycle against a reference model, so such faults are reported in the cycle they first appear.

// File: rtl/sec_rec_pkg.sv
package sec_rec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_DIV = 2'd1,
        ST_ERASING  = 2'd2,
        ST_DONE     = 2'd3
    } rec_state_e;

    typedef struct packed {
        logic erase_req;
        logic busy;
        logic lock;
    } fsm_out_t;

    function automatic fsm_out_t decode_state(rec_state_e s);
        fsm_out_t o;
        o.erase_req = (s == ST_ERASING);
        o.busy      = (s != ST_IDLE);
        o.lock      = (s == ST_ERASING) || (s == ST_DONE);
        return o;
    endfunction

endpackage

// File: rtl/sec_key_latch.sv
module sec_key_latch
    import sec_rec_pkg::*;
#(
    parameter int          KEY_BYTES = 2,
    parameter logic [7:0]  SEC_BYTE  = 8'hA5,
    localparam int         KEY_W     = 8 * KEY_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] sec_key,
    output logic             secured
);
    logic [KEY_BYTES-1:0] byte_hit;
    logic                 secured_q;

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_cmp
        assign byte_hit[g] = (sec_key[8*g +: 8] == SEC_BYTE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            secured_q <= &byte_hit;
        end
    end

    assign secured = secured_q;

    // R2: the latched security state never moves outside reset
    p_sec_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(secured_q))
        else $error("security bit changed outside reset");

endmodule

// File: rtl/erase_div_reg.sv
module erase_div_reg
    import sec_rec_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] value,
    input  logic             lock,
    output logic [DIV_W-1:0] div_q,
    output logic             div_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            div_valid <= 1'b0;
        end else if (load && !lock) begin
            div_q     <= value;
            div_valid <= 1'b1;
        end
    end

    // R8: divider frozen while the sequencer holds it locked
    p_div_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(div_q))
        else $error("divider changed while locked");

endmodule

// File: rtl/recovery_fsm.sv
module recovery_fsm
    import sec_rec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic recov_instr,
    input  logic div_valid,
    input  logic erase_done,
    output logic erase_req,
    output logic busy,
    output logic lock,
    output logic prot_clr
);
    rec_state_e state_q, state_d;
    fsm_out_t   outs;
    logic       prot_clr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (recov_instr) state_d = div_valid ? ST_ERASING : ST_WAIT_DIV;
            ST_WAIT_DIV: if (div_valid)   state_d = ST_ERASING;
            ST_ERASING:  if (erase_done)  state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            prot_clr_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            prot_clr_q <= (state_q == ST_ERASING) && erase_done;
        end
    end

    assign outs      = decode_state(state_q);
    assign erase_req = outs.erase_req;
    assign busy      = outs.busy;
    assign lock      = outs.lock;
    assign prot_clr  = prot_clr_q;

    // R4: no erase may start unless a divider is present
    p_no_start_nodiv_r4: assert property (@(posedge clk) disable iff (rst)
        (!div_valid && state_q != ST_ERASING) |=> state_q != ST_ERASING)
        else $error("erase started without divider");

    // R7: completion is terminal until reset
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DONE |=> state_q == ST_DONE)
        else $error("left done state without reset");

    // R6: the clear strobe follows only a completed erase
    p_prot_clr_r6: assert property (@(posedge clk) disable iff (rst)
        prot_clr_q |-> (state_q == ST_DONE && $past(state_q) == ST_ERASING))
        else $error("protection clear without erase completion");

    // R10: an erase request always comes with busy
    p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> busy)
        else $error("erase request while not busy");

endmodule

// File: rtl/sec_recovery_seq.sv
module sec_recovery_seq
    import sec_rec_pkg::*;
#(
    parameter int         KEY_BYTES = 2,
    parameter logic [7:0] SEC_BYTE  = 8'hA5,
    parameter int         DIV_W     = 7,
    localparam int        KEY_W     = 8 * KEY_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] sec_key,
    input  logic             recov_instr,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    input  logic             erase_done,
    output logic             erase_req,
    output logic [DIV_W-1:0] erase_clkdiv,
    output logic             prot_clr,
    output logic             dbg_rd_block,
    output logic             busy
);
    logic div_valid;
    logic lock;

    sec_key_latch #(.KEY_BYTES(KEY_BYTES), .SEC_BYTE(SEC_BYTE)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .sec_key (sec_key),
        .secured (dbg_rd_block)
    );

    erase_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_load),
        .value     (div_value),
        .lock      (lock),
        .div_q     (erase_clkdiv),
        .div_valid (div_valid)
    );

    recovery_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .recov_instr (recov_instr),
        .div_valid   (div_valid),
        .erase_done  (erase_done),
        .erase_req   (erase_req),
        .busy        (busy),
        .lock        (lock),
        .prot_clr    (prot_clr)
    );

    // R3: with no recovery instruction, an idle sequencer stays idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !recov_instr) |=> (!busy && !erase_req))
        else $error("sequencer left idle without instruction");

endmodule

// File: tb/sec_recovery_seq_bench.sv
module sec_recovery_seq_bench;
    localparam int KEY_BYTES = 2;
    localparam int KEY_W     = 8 * KEY_BYTES;
    localparam int DIV_W     = 7;

    logic             clk = 1'b0;
    logic             rst;
    logic [KEY_W-1:0] sec_key;
    logic             recov_instr;
    logic             div_load;
    logic [DIV_W-1:0] div_value;
    logic             erase_done;
    logic             erase_req;
    logic [DIV_W-1:0] erase_clkdiv;
    logic             prot_clr;
    logic             dbg_rd_block;
    logic             busy;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 pending, 2 erasing, 3 done
    int               m_st;
    logic             m_sec;
    logic             m_valid;
    logic [DIV_W-1:0] m_div;
    logic             m_pc;

    always #2 clk = ~clk;

    sec_recovery_seq #(.KEY_BYTES(KEY_BYTES), .DIV_W(DIV_W)) u_sec_recovery_seq (
        .clk(clk), .rst(rst), .sec_key(sec_key), .recov_instr(recov_instr),
        .div_load(div_load), .div_value(div_value), .erase_done(erase_done),
        .erase_req(erase_req), .erase_clkdiv(erase_clkdiv), .prot_clr(prot_clr),
        .dbg_rd_block(dbg_rd_block), .busy(busy)
    );

    function automatic logic key_secured(logic [KEY_W-1:0] k);
        logic s = 1'b1;
        for (int b = 0; b < KEY_BYTES; b++) if (k[8*b +: 8] != 8'hA5) s = 1'b0;
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // advance one clock: update the model from the current inputs, then compare
    task automatic cyc(string tag);
        int   nst = m_st;
        if (rst) begin
            m_sec = key_secured(sec_key); nst = 0; m_valid = 0; m_div = '0; m_pc = 0;
        end else begin
            logic old_valid = m_valid;
            m_pc = (m_st == 2) && erase_done;
            if (div_load && m_st < 2) begin m_div = div_value; m_valid = 1; end
            case (m_st)
                0: if (recov_instr) nst = old_valid ? 2 : 1;
                1: if (old_valid)   nst = 2;
                2: if (erase_done)  nst = 3;
                default: nst = m_st;
            endcase
        end
        m_st = nst;
        @(posedge clk); #1;
        chk({tag, " R1/R2 dbg"},  32'(dbg_rd_block), 32'(m_sec));
        chk({tag, " R5 req"},     32'(erase_req),    32'(m_st == 2));
        chk({tag, " R10 busy"},   32'(busy),         32'(m_st != 0));
        chk({tag, " R6 prot"},    32'(prot_clr),     32'(m_pc));
        chk({tag, " R8 div"},     32'(erase_clkdiv), 32'(m_div));
    endtask

    task automatic idle_in();
        recov_instr = 0; div_load = 0; erase_done = 0;
    endtask

    task automatic do_reset(logic [KEY_W-1:0] k, string tag);
        sec_key = k; rst = 1; idle_in();
        cyc(tag);
        rst = 0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0017));
        m_st = 0; m_sec = 0; m_valid = 0; m_div = '0; m_pc = 0;
        div_value = '0;

        // directed: reset with secure key (R1)
        do_reset(16'hA5A5, "R1 secure");
        chk("R1 secured after reset", 32'(dbg_rd_block), 32'd1);
        // R3: idle, no instruction
        cyc("R3 idle"); cyc("R3 idle");
        chk("R3 no busy", 32'(busy), 32'd0);
        // R2: key changes do not move the block
        sec_key = 16'hFFFF; cyc("R2 key change");
        chk("R2 still secured", 32'(dbg_rd_block), 32'd1);
        // R4: request without divider held pending
        recov_instr = 1; cyc("R4 req"); recov_instr = 0;
        cyc("R4 pend");
        chk("R4 pending no req", 32'(erase_req), 32'd0);
        chk("R4 pending busy", 32'(busy), 32'd1);
        div_load = 1; div_value = 7'h45; cyc("R4 load"); div_load = 0;
        cyc("R4 start");
        chk("R4 erase after load", 32'(erase_req), 32'd1);
        // R8: load during erase ignored
        div_load = 1; div_value = 7'h12; cyc("R8 ignore"); div_load = 0;
        chk("R8 div kept", 32'(erase_clkdiv), 32'h45);
        erase_done = 1; cyc("R6 done"); erase_done = 0;
        chk("R6 prot pulse", 32'(prot_clr), 32'd1);
        cyc("R6 pulse end");
        chk("R6 prot single", 32'(prot_clr), 32'd0);
        // R7: terminal state
        recov_instr = 1; erase_done = 1; cyc("R7 ignore"); cyc("R7 ignore"); idle_in();
        chk("R7 no req", 32'(erase_req), 32'd0);
        chk("R7 busy", 32'(busy), 32'd1);
        chk("R2 still secured after erase", 32'(dbg_rd_block), 32'd1);
        // R1: next reset with erased key unlocks
        do_reset(16'hFFFF, "R1 erased");
        chk("R1 unlocked after reset", 32'(dbg_rd_block), 32'd0);
        // R5/R9: divider first, erase, reset mid-erase with key still secure
        do_reset(16'hA5A5, "R9 setup");
        div_load = 1; div_value = 7'h7F; cyc("R5 load"); div_load = 0;
        recov_instr = 1; cyc("R5 req"); recov_instr = 0;
        chk("R5 immediate erase", 32'(erase_req), 32'd1);
        cyc("R5 hold"); cyc("R5 hold");
        chk("R5 req held", 32'(erase_req), 32'd1);
        do_reset(16'hA5A5, "R9 mid erase");
        chk("R9 idle after reset", 32'(busy), 32'd0);
        chk("R9 still secured", 32'(dbg_rd_block), 32'd1);
        chk("R9 divider cleared", 32'(erase_clkdiv), 32'd0);
        recov_instr = 1; cyc("R9 pend"); recov_instr = 0;
        chk("R9 valid cleared -> pending", 32'(erase_req), 32'd0);

        // constrained random sessions
        for (int t = 0; t < 80; t++) begin
            logic [KEY_W-1:0] k = ($urandom % 2) ? 16'hA5A5 : 16'($urandom);
            do_reset(k, "rand reset");
            for (int c = 0; c < 40; c++) begin
                int r = $urandom % 100;
                recov_instr = (r < 15);
                div_load    = (r >= 15 && r < 28);
                div_value   = 7'($urandom);
                erase_done  = (r >= 28 && r < 45);
                if ($urandom % 8 == 0) sec_key = 16'($urandom);
                cyc("rand");
            end
            idle_in();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule